// File: doc/BRIEF.md
# Synchronous Split-Port SRAM with Input Forwarding

A single-clock static memory with one input data bus and a separate output data bus. The address, the write data and every control input are captured in input registers on the rising clock edge. Read data leaves through an output register. Each cycle works on one address and may read it, write it, or both. When it does both, the word already stored is returned and the new word is stored afterwards.

A forwarding select sends the captured input word to the output register instead of the stored word. This supports transparent writes and data pass-through. An asynchronous, active-low output enable gates the output bus. Because the bus has no tri-state, the high-impedance state is shown as a cleared valid flag with the data forced to zero. Any cycle may follow any other cycle with no idle cycles in between.

The full-size configuration is 16 address bits by 18 data bits. The default address width is smaller, so that elaboration stays light.

Top module: `sio_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. Every address, from 0 up to 2^ADDR_W-1, maps to its own word.
- R2: All inputs except `out_en_n` are sampled on a rising edge n. The resulting word is loaded into the output register at edge n+1. It is therefore not yet visible after edge n.
- R3: A cycle is selected only when the sampled `cs_n` is 0 and the sampled `cs` is 1. Any other combination is a deselected cycle.
- R4: A selected cycle with `wr_n` = 0 stores `din` at `addr`. A selected cycle with `forward` = 0 loads the stored word at `addr` into the output register.
- R5: A selected cycle that both reads and writes the same address loads the previous contents into the output register, not the new word.
- R6: A selected cycle with `forward` = 1 loads the sampled `din` into the output register. If `wr_n` = 0 in that cycle, the array is still written.
- R7: A deselected cycle writes nothing and leaves the output register unchanged.
- R8: A write followed in the next cycle by a read of the same address returns the new word. No idle cycle is needed between them.
- R9: When `out_en_n` = 1, `dout` is 0 and `dout_valid` is 0 in the same cycle. When `out_en_n` = 0, `dout_valid` is 1 and `dout` shows the output register. Changing `out_en_n` does not change the output register.
- R10: A synchronous active-high `rst` clears the output register to 0 and makes the captured cycle a deselected one. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write / forwarding data |
| wr_n | input | 1 | Write request, active low |
| cs_n | input | 1 | Select, active low |
| cs | input | 1 | Select, active high |
| forward | input | 1 | Send `din` to the output instead of array data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Output data, zero while disabled |
| dout_valid | output | 1 | High while the output is enabled |

## Verification
A read and a write can fall on the same address in one cycle. A write to an address can also be followed directly by a read of that address. Directed cycles provoke both, and a long random run confined to eight addresses, with the forwarding select and output enable toggled, makes such collisions frequent. A behavioural model in the bench applies the old-word-first rule and predicts the output on every cycle. Checker properties relate the data sampled two and three edges earlier to the word that appears at the output.

// File: rtl/sio_sram_pkg.sv
package sio_sram_pkg;
  // Decoded control captured from one input cycle
  typedef struct packed {
    logic sel;  // chip selected
    logic wr;   // write requested
    logic fwd;  // send input word to output
  } sram_ctl_t;
endpackage

// File: rtl/sio_in_reg.sv
module sio_in_reg
  import sio_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              forward,
  output logic [ADDR_W-1:0] addr_r,
  output logic [DATA_W-1:0] din_r,
  output sram_ctl_t         ctl_r
);
  // Data path registers carry no reset so they map onto plain flops
  always_ff @(posedge clk) begin
    addr_r <= addr;
    din_r  <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= '0;
    end else begin
      ctl_r.sel <= ~cs_n & cs;
      ctl_r.wr  <= ~wr_n;
      ctl_r.fwd <= forward;
    end
  end
endmodule

// File: rtl/sio_array.sv
module sio_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single port: the read returns the word before this write
  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (en) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/sio_out_stage.sv
module sio_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              fwd,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic [DATA_W-1:0] ram_data,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  logic              fwd_q;
  logic [DATA_W-1:0] fwd_word_q;
  logic [DATA_W-1:0] word;

  // Forwarded word held beside the array output register
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q      <= 1'b0;
      fwd_word_q <= '0;
    end else if (load) begin
      fwd_q      <= fwd;
      fwd_word_q <= fwd_data;
    end
  end

  always_comb begin
    word       = fwd_q ? fwd_word_q : ram_data;
    dout_valid = ~out_en_n;
    dout       = out_en_n ? '0 : word;
  end
endmodule

// File: rtl/sio_sram.sv
module sio_sram
  import sio_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              forward,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] din_r;
  logic [DATA_W-1:0] ram_q;
  sram_ctl_t         ctl_r;

  sio_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .wr_n(wr_n),
    .cs_n(cs_n), .cs(cs), .forward(forward),
    .addr_r(addr_r), .din_r(din_r), .ctl_r(ctl_r)
  );

  sio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .en(ctl_r.sel), .we(ctl_r.wr),
    .addr(addr_r), .wdata(din_r), .rdata(ram_q)
  );

  sio_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(ctl_r.sel), .fwd(ctl_r.fwd),
    .fwd_data(din_r), .ram_data(ram_q), .out_en_n(out_en_n),
    .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/sio_sram_chk.sv
module sio_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              wr_n,
  input logic              cs_n,
  input logic              cs,
  input logic              forward,
  input logic              out_en_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid
);
  logic [1:0] since_rst;
  logic       sel_in;

  assign sel_in = ~cs_n & cs;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R9
  disabled_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (!dout_valid && dout == '0));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && !out_en_n && $past(!out_en_n) && !$past(sel_in, 2))
    |-> $stable(dout));

  // R6
  forward_word_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && !out_en_n && $past(sel_in && forward, 2))
    |-> dout == $past(din, 2));

  // R5 R8: a word written one cycle earlier is what the next access sees
  write_then_access_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !out_en_n
     && $past(sel_in && !wr_n, 3)
     && $past(sel_in && !forward, 2)
     && $past(addr, 2) == $past(addr, 3))
    |-> dout == $past(din, 3));
endmodule

bind sio_sram sio_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .din(din), .wr_n(wr_n),
  .cs_n(cs_n), .cs(cs), .forward(forward), .out_en_n(out_en_n),
  .dout(dout), .dout_valid(dout_valid)
);

// File: tb/tb_sio_sram.sv
module tb_sio_sram;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic wr_n = 1'b1, cs_n = 1'b1, cs = 1'b0, forward = 1'b0, out_en_n = 1'b0;
  logic [DW-1:0] dout;
  logic dout_valid;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R10";
  bit started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .wr_n(wr_n),
    .cs_n(cs_n), .cs(cs), .forward(forward), .out_en_n(out_en_n),
    .dout(dout), .dout_valid(dout_valid)
  );

  // Behavioural reference: one captured op, then the output word
  logic [DW-1:0] m_mem [DEPTH];
  logic m_sel = 1'b0, m_wr = 1'b0, m_fwd = 1'b0;
  logic [AW-1:0] m_a = '0;
  logic [DW-1:0] m_d = '0, m_q = '0;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_sel = 1'b0;
      m_q = '0;
    end else begin
      if (m_sel) begin
        m_q = m_fwd ? m_d : m_mem[m_a];
        if (m_wr) m_mem[m_a] = m_d;
      end
      m_sel = !cs_n && cs;
      m_wr = !wr_n;
      m_fwd = forward;
      m_a = addr;
      m_d = din;
    end
  end

  always @(negedge clk) begin
    logic [DW-1:0] exp_q;
    if (started) begin
      exp_q = out_en_n ? '0 : m_q;
      n_cmp++;
      if (dout !== exp_q || dout_valid !== !out_en_n) begin
        n_bad++;
        $display("FAIL %s: dout=%h valid=%b expected %h valid=%b",
                 cur_req, dout, dout_valid, exp_q, !out_en_n);
      end
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 1237 + 91);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic op_raw(logic [AW-1:0] a, logic [DW-1:0] dd, bit w,
                        bit sn, bit s, bit f);
    @(posedge clk); #1;
    addr = a; din = dd; wr_n = !w; cs_n = sn; cs = s; forward = f;
  endtask

  task automatic op(logic [AW-1:0] a, logic [DW-1:0] dd, bit w, bit f);
    op_raw(a, dd, w, 1'b0, 1'b1, f);
  endtask

  task automatic idle();
    op_raw('0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: output register cleared, enabled output shows zero
    chk("R10", dout, '0);
    chk("R10", {{(DW-1){1'b0}}, dout_valid}, DW'(1));

    // R4: fill every word with output hidden
    cur_req = "R4";
    out_en_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) op(AW'(a), pat(a), 1'b1, 1'b0);
    op('0, '0, 1'b0, 1'b0);
    idle(); idle();
    out_en_n = 1'b0;
    #1 chk("R4", dout, pat(0));

    // R2: one edge after capture the old word is still shown
    cur_req = "R2";
    op(AW'(3), '0, 1'b0, 1'b0);
    idle();
    chk("R2", dout, pat(0));
    idle();
    chk("R2", dout, pat(3));

    // R1: top address is a distinct word
    cur_req = "R1";
    op(AW'(DEPTH-1), '0, 1'b0, 1'b0); idle(); idle();
    chk("R1", dout, pat(DEPTH-1));

    // R5: combined read/write returns previous contents
    cur_req = "R5";
    op(AW'(7), 18'h2AAAA, 1'b1, 1'b0); idle(); idle();
    chk("R5", dout, pat(7));
    op(AW'(7), '0, 1'b0, 1'b0); idle(); idle();
    chk("R4", dout, 18'h2AAAA);

    // R6: forwarding without and with a write
    cur_req = "R6";
    op(AW'(9), 18'h15555, 1'b0, 1'b1); idle(); idle();
    chk("R6", dout, 18'h15555);
    op(AW'(9), '0, 1'b0, 1'b0); idle(); idle();
    chk("R6", dout, pat(9));
    op(AW'(9), 18'h0F0F0, 1'b1, 1'b1); idle(); idle();
    chk("R6", dout, 18'h0F0F0);
    op(AW'(9), '0, 1'b0, 1'b0); idle(); idle();
    chk("R6", dout, 18'h0F0F0);

    // R7 / R3: deselected writes change nothing
    cur_req = "R7";
    op_raw(AW'(11), 18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b0); idle(); idle();
    chk("R7", dout, 18'h0F0F0);
    cur_req = "R3";
    op_raw(AW'(11), 18'h3FFFF, 1'b1, 1'b0, 1'b0, 1'b0); idle(); idle();
    chk("R3", dout, 18'h0F0F0);
    op(AW'(11), '0, 1'b0, 1'b0); idle(); idle();
    chk("R3", dout, pat(11));

    // R8: write then immediate read of same address
    cur_req = "R8";
    op(AW'(20), 18'h12345, 1'b1, 1'b0);
    op(AW'(20), '0, 1'b0, 1'b0);
    idle(); idle();
    chk("R8", dout, 18'h12345);

    // R9: asynchronous output enable, register untouched
    cur_req = "R9";
    @(posedge clk); #1 out_en_n = 1'b1;
    #1 chk("R9", dout, '0);
    chk("R9", {{(DW-1){1'b0}}, dout_valid}, '0);
    out_en_n = 1'b0;
    #1 chk("R9", dout, 18'h12345);

    // R8 / R5: random traffic over a few addresses, model compared every cycle
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      op_raw(AW'($urandom_range(0, 7)), DW'($urandom), $urandom_range(0, 1) == 1,
             $urandom_range(0, 5) == 0, $urandom_range(0, 7) != 0,
             $urandom_range(0, 3) == 0);
      out_en_n = ($urandom_range(0, 9) == 0);
    end
    out_en_n = 1'b0;
    idle(); idle(); idle();
    summary();
    $finish;
  end
endmodule